// File: doc/BRIEF.md
# Manchester biphase word encoder

This block turns one 16-bit host word into a serial biphase frame for a dual-redundant 1 Mbit/s avionics data bus. It runs from a 12 MHz clock, so each bit lasts 12 clocks and each half-bit lasts 6 clocks. A frame has three parts. First comes a sync pattern three bit times long, whose polarity marks the word as a command/status word or a data word. Next come the sixteen data bits, most significant first, each Manchester coded. Last comes a parity bit that the block works out itself. A frame lasts 240 clocks.

The host writes a word into a one-entry holding register. The serializer then takes the word from there, either on the next bit boundary when the line is quiet, or at the exact end of the frame now being sent. A window flag tells the host when a queued word will follow the current frame with no gap. Two output lanes, A and B, each drive a pair of complementary logic levels for an external line driver. Each lane has its own disable input. The sync type and the lane are each the OR of a per-write input and a configuration input, and they are latched with every word.

Top module: `mbe_word_encoder`

## Requirements
- R1: After reset, and whenever no frame is in progress, all four lane outputs and `queue_ready` are low.
- R2: A frame is 40 half-bit slots of 6 clocks each. Slots 0-5 carry the sync. A command sync is high for slots 0-2 and low for slots 3-5; a data sync is low for slots 0-2 and high for slots 3-5. After the sync come data bits 15 down to 0, then the parity bit, each taking two slots. A bit value of 1 is high in its first slot and low in its second; a value of 0 is the reverse. "High" means `x_hi`=1 and `x_lo`=0.
- R3: The parity bit is chosen so that the 16 data bits plus the parity bit hold an odd number of ones.
- R4: The sync of a word is command when `host_cmd_sync` OR `cfg_cmd_sync` is 1 at the write, and data when both are 0.
- R5: The word goes out on lane B when `host_chan_b` OR `cfg_chan_b` is 1 at the write, and on lane A otherwise. The lane that is not selected stays low, and the two lanes are never active together.
- R6: Within a lane, `x_hi` and `x_lo` are never both high.
- R7: A word written while the line is idle starts on a bit boundary of a free-running 12-clock bit timer. So the first output cycles of any two frames are a multiple of 12 clocks apart, and a frame lasts exactly 240 clocks.
- R8: Counting the first output cycle of a frame as clock 0, `queue_ready` is high from clock 42 through clock 221 of that frame.
- R9: A word written during a frame, while the holding register is empty, is sent right after that frame with no idle cycle between them. Its own sync and lane settings are used.
- R10: A write while the holding register is occupied is ignored. Only the word already held is sent.
- R11: While a lane's disable input is high, that lane's outputs are low from the next clock on. The host side and `queue_ready` behave exactly as they do when the lane is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | One-cycle write strobe into the holding register |
| host_word | input | 16 | Word to send |
| host_cmd_sync | input | 1 | Per-write command sync request |
| host_chan_b | input | 1 | Per-write lane B request |
| cfg_cmd_sync | input | 1 | Configuration: force command sync |
| cfg_chan_b | input | 1 | Configuration: force lane B |
| lane_a_off | input | 1 | Disable lane A outputs |
| lane_b_off | input | 1 | Disable lane B outputs |
| queue_ready | output | 1 | Window in which a queued word follows without a gap |
| a_hi | output | 1 | Lane A positive level |
| a_lo | output | 1 | Lane A negative level |
| b_hi | output | 1 | Lane B positive level |
| b_lo | output | 1 | Lane B negative level |

## Verification
The bench decodes every slot of every frame in the middle of the slot and checks the result against a frame it builds itself from the word, the sync type and the parity. It sweeps all sixteen combinations of the sync and lane inputs, and it sends a chain of back-to-back words that walk a single one across all 16 bit positions. A design with the wrong parity sense, a reversed bit order or a sync polarity swapped would fail on the first decoded frame. A design that let a gap slip in between queued words, or that reused the previous word's lane, would be caught at the join between frames. The bench also checks the exact first and last cycles of the ready window. It checks that a second write into a full holding register does not replace the held word, and that a disabled lane stays quiet while the window flag still runs.

// File: rtl/mbe_pkg.sv
package mbe_pkg;
  localparam int WORD_W    = 16;
  localparam int SYNC_BITS = 3;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              cmd;
    logic              chan_b;
  } word_req_t;
endpackage

// File: rtl/mbe_bit_timer.sv
module mbe_bit_timer #(
  parameter int HALF_CLKS = 6
) (
  input  logic clk,
  input  logic rst,
  output logic half_end,
  output logic bit_end
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  logic [CW-1:0] cnt;
  logic          second_half;

  assign half_end = (cnt == CW'(HALF_CLKS - 1));
  assign bit_end  = half_end && second_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      second_half <= 1'b0;
    end else if (half_end) begin
      cnt         <= '0;
      second_half <= ~second_half;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mbe_hold_reg.sv
module mbe_hold_reg
  import mbe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  word_req_t wr_req,
  input  logic      take,
  output logic      valid,
  output word_req_t held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      held  <= '0;
    end else if (!valid && wr) begin
      valid <= 1'b1;
      held  <= wr_req;
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mbe_serializer.sv
module mbe_serializer
  import mbe_pkg::*;
#(
  parameter int HALF_CLKS  = 6,
  parameter int READY_RISE = 42,
  parameter int READY_FALL = 222
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      half_end,
  input  logic      bit_end,
  input  logic      hold_valid,
  input  word_req_t hold_word,
  output logic      take,
  output logic      active,
  output logic      chan_b,
  output logic      level,
  output logic      ready
);
  localparam int SHIFT_W     = WORD_W + 1;
  localparam int SYNC_HALVES = 2 * SYNC_BITS;
  localparam int SLOTS       = 2 * (SYNC_BITS + WORD_W + 1);
  localparam int FRAME_CLKS  = SLOTS * HALF_CLKS;
  localparam int SLOT_W      = $clog2(SLOTS);
  localparam int EL_W        = $clog2(FRAME_CLKS);

  logic [SLOT_W-1:0]  slot;
  logic [EL_W-1:0]    elapsed;
  logic [SHIFT_W-1:0] shreg;
  logic               cmd;
  logic               frame_last;
  logic               in_sync;

  assign frame_last = active && half_end && (slot == SLOT_W'(SLOTS - 1));
  assign take       = hold_valid && bit_end && (!active || frame_last);
  assign in_sync    = (slot < SLOT_W'(SYNC_HALVES));

  always_comb begin
    if (in_sync) begin
      level = cmd ? (slot < SLOT_W'(SYNC_BITS)) : (slot >= SLOT_W'(SYNC_BITS));
    end else begin
      level = slot[0] ? ~shreg[SHIFT_W-1] : shreg[SHIFT_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      slot    <= '0;
      elapsed <= '0;
      shreg   <= '0;
      cmd     <= 1'b0;
      chan_b  <= 1'b0;
    end else if (take) begin
      active  <= 1'b1;
      slot    <= '0;
      elapsed <= '0;
      shreg   <= {hold_word.data, ~^hold_word.data};
      cmd     <= hold_word.cmd;
      chan_b  <= hold_word.chan_b;
    end else if (frame_last) begin
      active <= 1'b0;
    end else if (active) begin
      elapsed <= elapsed + 1'b1;
      if (half_end) begin
        slot <= slot + 1'b1;
        if (!in_sync && slot[0]) begin
          shreg <= {shreg[SHIFT_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
    end else begin
      ready <= active && (elapsed >= EL_W'(READY_RISE)) && (elapsed < EL_W'(READY_FALL));
    end
  end
endmodule

// File: rtl/mbe_line_driver.sv
module mbe_line_driver (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic selected,
  input  logic off,
  input  logic level,
  output logic hi,
  output logic lo
);
  logic drive;
  assign drive = active && selected && !off;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= 1'b0;
      lo <= 1'b0;
    end else begin
      hi <= drive && level;
      lo <= drive && !level;
    end
  end
endmodule

// File: rtl/mbe_word_encoder.sv
module mbe_word_encoder
  import mbe_pkg::*;
#(
  parameter int HALF_CLKS  = 6,
  parameter int READY_RISE = 42,
  parameter int READY_FALL = 222
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_word,
  input  logic              host_cmd_sync,
  input  logic              host_chan_b,
  input  logic              cfg_cmd_sync,
  input  logic              cfg_chan_b,
  input  logic              lane_a_off,
  input  logic              lane_b_off,
  output logic              queue_ready,
  output logic              a_hi,
  output logic              a_lo,
  output logic              b_hi,
  output logic              b_lo
);
  localparam int LANES = 2;

  logic      half_end, bit_end;
  logic      take, active, chan_b, level;
  logic      hold_valid;
  word_req_t wr_req, held;

  logic [LANES-1:0] lane_off, lane_sel, lane_hi, lane_lo;

  assign wr_req.data   = host_word;
  assign wr_req.cmd    = host_cmd_sync | cfg_cmd_sync;
  assign wr_req.chan_b = host_chan_b | cfg_chan_b;

  mbe_bit_timer #(.HALF_CLKS(HALF_CLKS)) timer_i (
    .clk(clk), .rst(rst), .half_end(half_end), .bit_end(bit_end)
  );

  mbe_hold_reg hold_i (
    .clk(clk), .rst(rst), .wr(host_wr), .wr_req(wr_req),
    .take(take), .valid(hold_valid), .held(held)
  );

  mbe_serializer #(
    .HALF_CLKS(HALF_CLKS), .READY_RISE(READY_RISE), .READY_FALL(READY_FALL)
  ) ser_i (
    .clk(clk), .rst(rst), .half_end(half_end), .bit_end(bit_end),
    .hold_valid(hold_valid), .hold_word(held), .take(take),
    .active(active), .chan_b(chan_b), .level(level), .ready(queue_ready)
  );

  assign lane_off = {lane_b_off, lane_a_off};
  assign lane_sel = {chan_b, ~chan_b};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mbe_line_driver drv_i (
      .clk(clk), .rst(rst), .active(active), .selected(lane_sel[g]),
      .off(lane_off[g]), .level(level), .hi(lane_hi[g]), .lo(lane_lo[g])
    );
  end

  assign a_hi = lane_hi[0];
  assign a_lo = lane_lo[0];
  assign b_hi = lane_hi[1];
  assign b_lo = lane_lo[1];
endmodule

// File: rtl/mbe_word_encoder_chk.sv
module mbe_word_encoder_chk #(
  parameter int HALF_CLKS = 6
) (
  input logic clk,
  input logic rst,
  input logic lane_a_off,
  input logic lane_b_off,
  input logic a_hi,
  input logic a_lo,
  input logic b_hi,
  input logic b_lo
);
  localparam int MAX_RUN = 4 * HALF_CLKS;
  localparam int RW      = $clog2(MAX_RUN + 2);

  logic [3:0] outs;
  assign outs = {b_lo, b_hi, a_lo, a_hi};

  for (genvar g = 0; g < 4; g++) begin : g_run
    logic [RW-1:0] run;
    always_ff @(posedge clk) begin
      if (rst || !outs[g]) run <= '0;
      else if (run <= RW'(MAX_RUN)) run <= run + 1'b1;
    end
    // R2: no level of a frame is held longer than sync half plus one half-bit
    p_max_run_r2: assert property (@(posedge clk) disable iff (rst)
      run <= RW'(MAX_RUN));
  end

  p_pair_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(a_hi && a_lo) && !(b_hi && b_lo));

  p_one_lane_r5: assert property (@(posedge clk) disable iff (rst)
    !((a_hi || a_lo) && (b_hi || b_lo)));

  p_off_a_r11: assert property (@(posedge clk) disable iff (rst)
    lane_a_off |=> !(a_hi || a_lo));

  p_off_b_r11: assert property (@(posedge clk) disable iff (rst)
    lane_b_off |=> !(b_hi || b_lo));
endmodule

bind mbe_word_encoder mbe_word_encoder_chk #(.HALF_CLKS(HALF_CLKS)) chk_i (
  .clk(clk), .rst(rst), .lane_a_off(lane_a_off), .lane_b_off(lane_b_off),
  .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
);

// File: tb/mbe_word_encoder_tb_top.sv
module mbe_word_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;
  localparam int FRAME_CLKS = 240;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [15:0] host_word = '0;
  logic        host_cmd_sync = 1'b0, host_chan_b = 1'b0;
  logic        cfg_cmd_sync = 1'b0, cfg_chan_b = 1'b0;
  logic        lane_a_off = 1'b0, lane_b_off = 1'b0;
  logic        queue_ready, a_hi, a_lo, b_hi, b_lo;

  int n_chk = 0, n_fail = 0, cyc = 0, first_start = -1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbe_word_encoder dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_word(host_word),
    .host_cmd_sync(host_cmd_sync), .host_chan_b(host_chan_b),
    .cfg_cmd_sync(cfg_cmd_sync), .cfg_chan_b(cfg_chan_b),
    .lane_a_off(lane_a_off), .lane_b_off(lane_b_off),
    .queue_ready(queue_ready), .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= MAX_CYCLES && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, MAX_CYCLES);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_level(input logic [15:0] w, input bit cmd, input int s);
    int k; bit v;
    if (s < 6) return cmd ? (s < 3) : (s >= 3);
    k = (s - 6) / 2;
    v = (k < 16) ? w[15-k] : ~^w;
    return (s % 2 == 0) ? v : !v;
  endfunction

  task automatic write_word(input logic [15:0] w, input bit cs, input bit cb);
    host_wr = 1'b1; host_word = w; host_cmd_sync = cs; host_chan_b = cb;
    @(negedge clk);
    host_wr = 1'b0; host_cmd_sync = 1'b0; host_chan_b = 1'b0;
  endtask

  // Decodes one frame; optionally queues a word at clock 100 of the frame.
  task automatic run_frame(input logic [15:0] w, input bit cmd, input bit ch,
                           input bit q_en, input logic [15:0] qw, input bit qs,
                           input bit qc, input bit exp_next, input string req);
    int wait_n; bit hi, lo, ohi, olo; int bad;
    wait_n = 0;
    while (!((ch ? b_hi : a_hi) || (ch ? b_lo : a_lo)) && wait_n < 40) begin
      @(negedge clk); wait_n++;
    end
    chk(wait_n < 40, {req, " start"}, wait_n, 0);
    if (wait_n >= 40) return;
    if (first_start < 0) first_start = cyc;
    chk((cyc - first_start) % 12 == 0, "R7 bit boundary", (cyc - first_start) % 12, 0);
    bad = 0;
    for (int j = 0; j < FRAME_CLKS; j++) begin
      hi = ch ? b_hi : a_hi; lo = ch ? b_lo : a_lo;
      ohi = ch ? a_hi : b_hi; olo = ch ? a_lo : b_lo;
      if (j % 6 == 3) begin
        if (hi != exp_level(w, cmd, j/6) || lo == hi) begin
          bad++;
          $display("FAIL %s R2/R3 slot %0d actual=%0b%0b expected=%0b", req, j/6, hi, lo,
                   exp_level(w, cmd, j/6));
        end
        if (ohi || olo) begin
          bad++;
          $display("FAIL R5 other lane active slot %0d actual=%0b%0b expected=00", j/6, ohi, olo);
        end
      end
      if (j == 41 || j == 42 || j == 221 || j == 222)
        chk(queue_ready == (j >= 42 && j < 222), "R8 ready edge", queue_ready, (j >= 42 && j < 222));
      if (q_en && j == 100) begin
        host_wr = 1'b1; host_word = qw; host_cmd_sync = qs; host_chan_b = qc;
      end
      if (q_en && j == 101) begin
        host_wr = 1'b0; host_cmd_sync = 1'b0; host_chan_b = 1'b0;
      end
      @(negedge clk);
    end
    n_chk++; if (bad != 0) n_fail++;
    if (exp_next)
      chk(a_hi || a_lo || b_hi || b_lo, "R9 no gap", 0, 1);
    else
      chk(!(a_hi || a_lo || b_hi || b_lo), "R7/R1 idle after 240 clocks",
          {a_hi, a_lo, b_hi, b_lo}, 0);
  endtask

  function automatic logic [15:0] chain_word(input int k);
    if (k < 16) return 16'h1 << k;
    case (k)
      16: return 16'h0000;
      17: return 16'hFFFF;
      18: return 16'h8001;
      default: return 16'h7FFE;
    endcase
  endfunction

  initial begin
    int ready_cnt, a_bad;
    repeat (5) @(negedge clk);
    chk({queue_ready, a_hi, a_lo, b_hi, b_lo} == 0, "R1 reset state", {queue_ready, a_hi, a_lo, b_hi, b_lo}, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk({queue_ready, a_hi, a_lo, b_hi, b_lo} == 0, "R1 idle state", {queue_ready, a_hi, a_lo, b_hi, b_lo}, 0);

    // R4 R5: all OR combinations of sync and lane inputs
    for (int i = 0; i < 16; i++) begin
      logic [15:0] w;
      w = 16'hA5C3 ^ (16'(i) * 16'h1111);
      cfg_cmd_sync = i[0]; cfg_chan_b = i[2];
      write_word(w, i[1], i[3]);
      run_frame(w, i[0] | i[1], i[2] | i[3], 1'b0, '0, 1'b0, 1'b0, 1'b0, "R4/R5 combo");
      repeat (7) @(negedge clk);
    end
    cfg_cmd_sync = 1'b0; cfg_chan_b = 1'b0;

    // R9 R3: back-to-back chain of walking ones and extreme patterns
    write_word(chain_word(0), 1'b0, 1'b1);
    for (int k = 0; k < 20; k++) begin
      run_frame(chain_word(k), k % 2 == 1, k % 3 == 0, k < 19, chain_word(k + 1),
                (k + 1) % 2 == 1, (k + 1) % 3 == 0, k < 19, "R9 chain");
    end
    repeat (10) @(negedge clk);

    // R10: second write into a full holding register is dropped
    write_word(16'h1234, 1'b1, 1'b0);
    write_word(16'hFEDC, 1'b0, 1'b0);
    run_frame(16'h1234, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R10 held word");
    repeat (30) @(negedge clk);
    chk(!(a_hi || a_lo || b_hi || b_lo), "R10 dropped word not sent", {a_hi, a_lo, b_hi, b_lo}, 0);

    // R11: disabled lane A stays quiet, ready window still runs
    lane_a_off = 1'b1;
    write_word(16'h5A5A, 1'b0, 1'b0);
    ready_cnt = 0; a_bad = 0;
    for (int j = 0; j < 280; j++) begin
      if (queue_ready) ready_cnt++;
      if (a_hi || a_lo || b_hi || b_lo) a_bad++;
      @(negedge clk);
    end
    chk(a_bad == 0, "R11 disabled lane quiet", a_bad, 0);
    chk(ready_cnt == 180, "R11 ready unaffected", ready_cnt, 180);
    lane_a_off = 1'b0;

    // R11: disabling lane B leaves lane A unaffected
    lane_b_off = 1'b1;
    write_word(16'hC0DE, 1'b1, 1'b0);
    run_frame(16'hC0DE, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R11 other lane off");
    lane_b_off = 1'b0;
    repeat (5) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule